// File: doc/BRIEF.md
# Four-Channel Complementary PWM with Trip Shutdown

The block generates four pulse-width-modulated signals from one shared 16-bit up-counter. Each channel compares the counter against its own turn-on and turn-off positions and produces a true output and a complementary output. Before either output of a pair may go high, it must wait a programmable number of clocks after its partner went low. An optional pairwise AND/OR combining stage sits after the gap logic. A set of trip inputs, each enabled separately, overrides every output at once. The override drives the outputs to programmed safe levels and latches a sticky flag, which can also raise an interrupt.

Configuration goes through a flat byte-register port. The write port changes a register on the clock edge where `wr_en` is high. The read port returns the addressed register one clock after the address is applied. All outputs are registered, so a change to the counter or to the configuration reaches the pins one clock later. A typical user programs the period and the edge positions, then the gap and the combining mode, then the trip setup, and finally sets the pair enable and the channel enables.

Top module: `cpwm_trip`

## Requirements
- R1: After synchronous reset all outputs are low, the irq is low, and every register, the trip flag included, reads as zero.
- R2: The counter holds at 0 while the pair enable (control byte at address 0, bit 3) is clear. Otherwise it counts 0,1,…,P and wraps to 0, where P is the 16-bit period at addresses 4 (low) and 5 (high). One period therefore lasts P+1 clocks.
- R3: A channel's raw level is high when the counter value c satisfies rise ≤ c < fall. Rise and fall are 16 bits each, stored low byte first: channel n's rise is at 8+4n/9+4n and its fall at 10+4n/11+4n. With a gap of 0, the true output follows the raw level two clocks later.
- R4: With a gap of 0 and no combining, the complementary output is the inverse of the true output for an enabled channel.
- R5: The gap field (address 1, bits 3:0) delays each rising edge of both the true and the complementary output by that many clocks. Falling edges are not delayed. With combining off, a true output and its complementary output are never high together.
- R6: Channel n is active only when its enable (address 0, bit 4+n) is set. The multi mode bit (address 0, bit 0) must also be set for channels 1 to 3, because with it clear only channel 0 runs. An inactive channel drives both its outputs low.
- R7: With the master bit (address 0, bit 1) set, every channel uses channel 0's rise and fall values.
- R8: Combining is set by address 1, bits 5:4 for the true outputs and bits 7:6 for the complementary outputs. Each channel combines with its partner n^1. The codes are: 0 = own value, 1 = AND with partner, 2 = OR with partner, 3 = AND on even channels and OR on odd channels.
- R9: With the pair enable clear and no trip, all true and complementary outputs are low.
- R10: A trip input takes effect only when it is unmasked and the global trip enable is set. The input mask is at address 2, bits 3:0, and the global enable is at address 0, bit 2. In the clock after a qualifying trip input is seen, the outputs are forced. With the select bit set (address 2, bit 6), the true outputs take the level in bit 4 and the complementary outputs take the level in bit 5. With the select bit clear, all outputs are forced low.
- R11: The trip flag (address 3, bit 0) is sticky. Writing 1 to that bit clears it, but a trip input that is still active wins over the clear. Outputs stay forced while the flag is set. The irq output equals the flag ANDed with the interrupt enable (address 2, bit 7).
- R12: Reading an address returns that register's stored byte one clock after the read address is applied. Unmapped addresses read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | AW | Read address |
| rd_data | output | 8 | Registered read data |
| trip_i | input | NCH | Trip inputs, active high |
| pwm_o | output | NCH | True outputs |
| pwmn_o | output | NCH | Complementary outputs |
| irq_o | output | 1 | Trip interrupt |

## Verification
The bench targets the gap counter at channel edges. A design that delayed falling edges as well as rising ones, or that restarted the count wrongly, would show the wrong number of high clocks per period or an overlap of the two outputs of a pair. It also attacks the flag clear while a trip input is still high. A clear-wins design would release the outputs while the fault is present. Masked inputs and a disabled global trip are driven to catch a design that trips on every input. Random reconfiguration mid-period with master, multi and combining modes catches wrong partner selection or edge sharing, since such errors make the outputs depart from the bench's cycle model.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;
  localparam int CNT_W  = 16;
  localparam int DEAD_W = 4;

  localparam int A_CTRL  = 0;
  localparam int A_SHAPE = 1;
  localparam int A_TRIP  = 2;
  localparam int A_STAT  = 3;
  localparam int A_PLO   = 4;
  localparam int A_PHI   = 5;
  localparam int CH_BASE = 8;

  typedef struct packed {
    logic [3:0]        gen_en;
    logic              pair_en;
    logic              trip_en;
    logic              master;
    logic              multi;
    logic [1:0]        cmb_c;
    logic [1:0]        cmb_t;
    logic [DEAD_W-1:0] dead;
    logic              irq_en;
    logic              tri_sel;
    logic              lvl_c;
    logic              lvl_t;
    logic [3:0]        trip_mask;
  } cpwm_cfg_t;

  function automatic logic cpwm_pair(input logic [1:0] mode, input logic self_v,
                                     input logic mate_v, input logic even);
    logic r;
    case (mode)
      2'd0:    r = self_v;
      2'd1:    r = self_v & mate_v;
      2'd2:    r = self_v | mate_v;
      default: r = even ? (self_v & mate_v) : (self_v | mate_v);
    endcase
    return r;
  endfunction
endpackage

// File: rtl/cpwm_regs.sv
module cpwm_regs import cpwm_pkg::*; #(
  parameter int NCH = 4,
  parameter int AW  = 5
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_en,
  input  logic [AW-1:0]             wr_addr,
  input  logic [7:0]                wr_data,
  input  logic [AW-1:0]             rd_addr,
  input  logic                      flag_i,
  output cpwm_cfg_t                 cfg_o,
  output logic [CNT_W-1:0]          period_o,
  output logic [NCH-1:0][CNT_W-1:0] rise_o,
  output logic [NCH-1:0][CNT_W-1:0] fall_o,
  output logic                      clr_o,
  output logic [7:0]                rd_data_o
);
  logic [7:0] ctrl_q, shape_q, trip_q;
  logic [CNT_W-1:0] period_q;
  logic [NCH-1:0][CNT_W-1:0] rise_q, fall_q;
  logic [7:0] rd_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q   <= '0;
      shape_q  <= '0;
      trip_q   <= '0;
      period_q <= '0;
      rise_q   <= '0;
      fall_q   <= '0;
    end else if (wr_en) begin
      if (wr_addr == AW'(A_CTRL))  ctrl_q  <= wr_data;
      if (wr_addr == AW'(A_SHAPE)) shape_q <= wr_data;
      if (wr_addr == AW'(A_TRIP))  trip_q  <= wr_data;
      if (wr_addr == AW'(A_PLO))   period_q[7:0]  <= wr_data;
      if (wr_addr == AW'(A_PHI))   period_q[15:8] <= wr_data;
      for (int i = 0; i < NCH; i++) begin
        if (wr_addr == AW'(CH_BASE + 4*i))     rise_q[i][7:0]  <= wr_data;
        if (wr_addr == AW'(CH_BASE + 4*i + 1)) rise_q[i][15:8] <= wr_data;
        if (wr_addr == AW'(CH_BASE + 4*i + 2)) fall_q[i][7:0]  <= wr_data;
        if (wr_addr == AW'(CH_BASE + 4*i + 3)) fall_q[i][15:8] <= wr_data;
      end
    end
  end

  always_comb begin
    rd_n = '0;
    if (rd_addr == AW'(A_CTRL))  rd_n = ctrl_q;
    if (rd_addr == AW'(A_SHAPE)) rd_n = shape_q;
    if (rd_addr == AW'(A_TRIP))  rd_n = trip_q;
    if (rd_addr == AW'(A_STAT))  rd_n = {7'd0, flag_i};
    if (rd_addr == AW'(A_PLO))   rd_n = period_q[7:0];
    if (rd_addr == AW'(A_PHI))   rd_n = period_q[15:8];
    for (int i = 0; i < NCH; i++) begin
      if (rd_addr == AW'(CH_BASE + 4*i))     rd_n = rise_q[i][7:0];
      if (rd_addr == AW'(CH_BASE + 4*i + 1)) rd_n = rise_q[i][15:8];
      if (rd_addr == AW'(CH_BASE + 4*i + 2)) rd_n = fall_q[i][7:0];
      if (rd_addr == AW'(CH_BASE + 4*i + 3)) rd_n = fall_q[i][15:8];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data_o <= '0;
    else     rd_data_o <= rd_n;
  end

  assign cfg_o    = {ctrl_q, shape_q, trip_q};
  assign period_o = period_q;
  assign rise_o   = rise_q;
  assign fall_o   = fall_q;
  assign clr_o    = wr_en && (wr_addr == AW'(A_STAT)) && wr_data[0];
endmodule

// File: rtl/cpwm_base.sv
module cpwm_base import cpwm_pkg::*; (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_i,
  input  logic [CNT_W-1:0] period_i,
  output logic [CNT_W-1:0] cnt_o
);
  always_ff @(posedge clk) begin
    if (rst || !run_i)          cnt_o <= '0;
    else if (cnt_o >= period_i) cnt_o <= '0;
    else                        cnt_o <= cnt_o + 1'b1;
  end

  // R2: wrap at the period end
  p_wrap_r2: assert property (@(posedge clk) disable iff (rst)
    (run_i && cnt_o >= period_i) |=> (cnt_o == '0));
  // R2: held at zero when stopped
  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !run_i |=> (cnt_o == '0));
endmodule

// File: rtl/cpwm_dead.sv
module cpwm_dead #(
  parameter int DW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          raw_i,
  input  logic [DW-1:0] dead_i,
  output logic          hi_o,
  output logic          lo_o
);
  logic          lvl_q;
  logic [DW-1:0] run_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_q <= 1'b0;
      run_q <= '0;
    end else if (raw_i != lvl_q) begin
      lvl_q <= raw_i;
      run_q <= '0;
    end else if (run_q != {DW{1'b1}}) begin
      run_q <= run_q + 1'b1;
    end
  end

  assign hi_o = lvl_q  && (run_q >= dead_i);
  assign lo_o = !lvl_q && (run_q >= dead_i);
endmodule

// File: rtl/cpwm_guard.sv
module cpwm_guard #(
  parameter int NTR = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NTR-1:0] trip_i,
  input  logic [NTR-1:0] mask_i,
  input  logic           en_i,
  input  logic           clr_i,
  output logic           hit_o,
  output logic           flag_o
);
  assign hit_o = en_i && |(trip_i & mask_i);

  always_ff @(posedge clk) begin
    if (rst) flag_o <= 1'b0;
    else     flag_o <= (flag_o && !clr_i) || hit_o;
  end

  // R11: flag holds until cleared
  p_sticky_r11: assert property (@(posedge clk) disable iff (rst)
    (flag_o && !clr_i) |=> flag_o);
  // R10: a qualifying trip always latches
  p_set_r10: assert property (@(posedge clk) disable iff (rst)
    hit_o |=> flag_o);
endmodule

// File: rtl/cpwm_trip.sv
module cpwm_trip import cpwm_pkg::*; #(
  parameter int NCH = 4,
  parameter int AW  = 5
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wr_en,
  input  logic [AW-1:0]  wr_addr,
  input  logic [7:0]     wr_data,
  input  logic [AW-1:0]  rd_addr,
  output logic [7:0]     rd_data,
  input  logic [NCH-1:0] trip_i,
  output logic [NCH-1:0] pwm_o,
  output logic [NCH-1:0] pwmn_o,
  output logic           irq_o
);
  cpwm_cfg_t                 cfg;
  logic [CNT_W-1:0]          period, cnt;
  logic [NCH-1:0][CNT_W-1:0] rise, fall;
  logic                      clr, flag, hit, trip_force;
  logic [NCH-1:0]            raw, t_g, c_g, active, tm, cm, mt, mc;

  cpwm_regs #(.NCH(NCH), .AW(AW)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .flag_i(flag), .cfg_o(cfg), .period_o(period),
    .rise_o(rise), .fall_o(fall), .clr_o(clr), .rd_data_o(rd_data));

  cpwm_base u_base (
    .clk(clk), .rst(rst), .run_i(cfg.pair_en), .period_i(period), .cnt_o(cnt));

  cpwm_guard #(.NTR(NCH)) u_guard (
    .clk(clk), .rst(rst), .trip_i(trip_i), .mask_i(cfg.trip_mask[NCH-1:0]),
    .en_i(cfg.trip_en), .clr_i(clr), .hit_o(hit), .flag_o(flag));

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    localparam int PG = g ^ 1;
    logic [CNT_W-1:0] r_sel, f_sel;
    assign r_sel     = cfg.master ? rise[0] : rise[g];
    assign f_sel     = cfg.master ? fall[0] : fall[g];
    assign raw[g]    = (cnt >= r_sel) && (cnt < f_sel);
    assign active[g] = cfg.gen_en[g] && (cfg.multi || (g == 0));

    cpwm_dead #(.DW(DEAD_W)) u_dead (
      .clk(clk), .rst(rst), .raw_i(raw[g]), .dead_i(cfg.dead),
      .hi_o(t_g[g]), .lo_o(c_g[g]));

    assign tm[g] = t_g[g] & active[g];
    assign cm[g] = c_g[g] & active[g];
    assign mt[g] = cpwm_pair(cfg.cmb_t, tm[g], tm[PG], (g % 2) == 0);
    assign mc[g] = cpwm_pair(cfg.cmb_c, cm[g], cm[PG], (g % 2) == 0);
  end

  assign trip_force = flag || hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      pwm_o  <= '0;
      pwmn_o <= '0;
    end else if (trip_force) begin
      pwm_o  <= cfg.tri_sel ? {NCH{cfg.lvl_t}} : '0;
      pwmn_o <= cfg.tri_sel ? {NCH{cfg.lvl_c}} : '0;
    end else if (!cfg.pair_en) begin
      pwm_o  <= '0;
      pwmn_o <= '0;
    end else begin
      pwm_o  <= mt;
      pwmn_o <= mc;
    end
  end

  assign irq_o = flag && cfg.irq_en;

  logic tri_sel, lvl_t, lvl_c, pair_en;
  logic [1:0] cmb_t, cmb_c;
  assign tri_sel = cfg.tri_sel;
  assign lvl_t   = cfg.lvl_t;
  assign lvl_c   = cfg.lvl_c;
  assign pair_en = cfg.pair_en;
  assign cmb_t   = cfg.cmb_t;
  assign cmb_c   = cfg.cmb_c;

  // R10: forced levels follow a trip
  p_trip_levels_r10: assert property (@(posedge clk) disable iff (rst)
    trip_force |=> (pwm_o == ($past(tri_sel) ? {NCH{$past(lvl_t)}} : '0)) &&
                   (pwmn_o == ($past(tri_sel) ? {NCH{$past(lvl_c)}} : '0)));
  // R9: pair enable off silences everything
  p_pair_off_r9: assert property (@(posedge clk) disable iff (rst)
    (!pair_en && !trip_force) |=> (pwm_o == '0) && (pwmn_o == '0));
  // R5: no overlap of a pair without combining
  p_no_overlap_r5: assert property (@(posedge clk) disable iff (rst)
    (cmb_t == 2'd0 && cmb_c == 2'd0 && !trip_force) |=> ((pwm_o & pwmn_o) == '0));
endmodule

// File: tb/cpwm_trip_tb_top.sv
module cpwm_trip_tb_top;
  logic       clk = 0;
  logic       rst = 1;
  logic       wr_en = 0;
  logic [4:0] wr_addr = 0;
  logic [7:0] wr_data = 0;
  logic [4:0] rd_addr = 0;
  logic [7:0] rd_data;
  logic [3:0] trip_i = 0;
  logic [3:0] pwm_o, pwmn_o;
  logic       irq_o;

  always #2 clk = ~clk;

  cpwm_trip dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .trip_i(trip_i),
    .pwm_o(pwm_o), .pwmn_o(pwmn_o), .irq_o(irq_o));

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;
  bit cmp_on = 0;
  string cur_req = "R1";

  // cycle model built from the requirements
  logic [7:0]  s_ctrl, s_shape, s_trip;
  logic [15:0] s_per;
  logic [15:0] s_rise [4];
  logic [15:0] s_fall [4];
  logic [15:0] m_cnt;
  logic [3:0]  m_prev, m_pwm, m_pwmn;
  logic [3:0]  m_run [4];
  logic        m_flag;

  function automatic logic [3:0] mix_exp(input logic [3:0] v, input logic [1:0] m);
    logic [3:0] r;
    for (int i = 0; i < 4; i++) begin
      logic a, b;
      a = v[i]; b = v[i ^ 1];
      case (m)
        2'd0: r[i] = a;
        2'd1: r[i] = a & b;
        2'd2: r[i] = a | b;
        default: r[i] = (i % 2 == 0) ? (a & b) : (a | b);
      endcase
    end
    return r;
  endfunction

  always @(posedge clk) begin : model
    logic [3:0] raw, tg, cg, act;
    logic [15:0] rs, fs;
    logic hit;
    if (rst) begin
      s_ctrl <= 0; s_shape <= 0; s_trip <= 0; s_per <= 0;
      for (int i = 0; i < 4; i++) begin
        s_rise[i] <= 0; s_fall[i] <= 0; m_run[i] <= 0;
      end
      m_cnt <= 0; m_prev <= 0; m_pwm <= 0; m_pwmn <= 0; m_flag <= 0;
    end else begin
      if (wr_en) begin
        case (wr_addr)
          5'd0: s_ctrl  <= wr_data;
          5'd1: s_shape <= wr_data;
          5'd2: s_trip  <= wr_data;
          5'd4: s_per[7:0]  <= wr_data;
          5'd5: s_per[15:8] <= wr_data;
          default: if (wr_addr >= 8 && wr_addr < 24) begin
            case (wr_addr % 4)
              0: s_rise[(wr_addr - 8) / 4][7:0]  <= wr_data;
              1: s_rise[(wr_addr - 8) / 4][15:8] <= wr_data;
              2: s_fall[(wr_addr - 8) / 4][7:0]  <= wr_data;
              default: s_fall[(wr_addr - 8) / 4][15:8] <= wr_data;
            endcase
          end
        endcase
      end
      m_cnt <= !s_ctrl[3] ? 16'd0 : (m_cnt >= s_per ? 16'd0 : m_cnt + 16'd1);
      for (int i = 0; i < 4; i++) begin
        rs = s_ctrl[1] ? s_rise[0] : s_rise[i];
        fs = s_ctrl[1] ? s_fall[0] : s_fall[i];
        raw[i] = (m_cnt >= rs) && (m_cnt < fs);
        tg[i]  = m_prev[i]  && (m_run[i] >= s_shape[3:0]);
        cg[i]  = !m_prev[i] && (m_run[i] >= s_shape[3:0]);
        act[i] = s_ctrl[4+i] && (s_ctrl[0] || i == 0);
        if (raw[i] == m_prev[i]) m_run[i] <= (m_run[i] == 4'hF) ? 4'hF : m_run[i] + 4'd1;
        else m_run[i] <= 0;
      end
      m_prev <= raw;
      hit = s_ctrl[2] && |(trip_i & s_trip[3:0]);
      m_flag <= (m_flag && !(wr_en && wr_addr == 5'd3 && wr_data[0])) || hit;
      if (m_flag || hit) begin
        m_pwm  <= s_trip[6] ? {4{s_trip[4]}} : 4'h0;
        m_pwmn <= s_trip[6] ? {4{s_trip[5]}} : 4'h0;
      end else if (!s_ctrl[3]) begin
        m_pwm <= 0; m_pwmn <= 0;
      end else begin
        m_pwm  <= mix_exp(tg & act, s_shape[5:4]);
        m_pwmn <= mix_exp(cg & act, s_shape[7:6]);
      end
    end
  end

  task automatic check(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on && !rst && !done) begin
      check(cur_req, "pwm",  {12'd0, pwm_o},  {12'd0, m_pwm});
      check(cur_req, "pwmn", {12'd0, pwmn_o}, {12'd0, m_pwmn});
      check(cur_req, "irq",  {15'd0, irq_o},  {15'd0, m_flag && s_trip[7]});
    end
  end

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input logic [4:0] a, input logic [7:0] exp, input string req);
    rd_addr = a;
    @(negedge clk);
    check(req, "rd_data", {8'd0, rd_data}, {8'd0, exp});
  endtask

  task automatic set_ch(input int ch, input logic [15:0] r, input logic [15:0] f);
    wr(5'(8 + 4*ch), r[7:0]);     wr(5'(9 + 4*ch), r[15:8]);
    wr(5'(10 + 4*ch), f[7:0]);    wr(5'(11 + 4*ch), f[15:8]);
  endtask

  task automatic count_high(input int cyc, input int ch, output int hi_t, output int hi_c);
    hi_t = 0; hi_c = 0;
    for (int k = 0; k < cyc; k++) begin
      @(negedge clk);
      hi_t += int'(pwm_o[ch]);
      hi_c += int'(pwmn_o[ch]);
    end
  endtask

  initial begin
    int ht, hc;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", "pwm in reset", {12'd0, pwm_o}, 16'd0);
    check("R1", "pwmn in reset", {12'd0, pwmn_o}, 16'd0);
    check("R1", "irq in reset", {15'd0, irq_o}, 16'd0);
    rst = 0;
    @(negedge clk);
    cmp_on = 1;
    rd(5'd0, 8'h00, "R1");
    rd(5'd3, 8'h00, "R1");
    rd(5'd8, 8'h00, "R1");

    // R12: readback of a 16-bit value, low byte first, and unmapped address
    cur_req = "R12";
    wr(5'd8, 8'h34); wr(5'd9, 8'h12);
    rd(5'd8, 8'h34, "R12");
    rd(5'd9, 8'h12, "R12");
    rd(5'd6, 8'h00, "R12");

    // R2 R3 R4: basic shapes, period 20 clocks
    cur_req = "R3";
    wr(5'd4, 8'd19); wr(5'd5, 8'd0);
    set_ch(0, 16'd3, 16'd10);
    set_ch(1, 16'd5, 16'd15);
    set_ch(2, 16'd0, 16'd20);
    set_ch(3, 16'd12, 16'd4);
    wr(5'd1, 8'h00);
    wr(5'd0, 8'hF9);          // all gens, pair, multi
    repeat (10) @(negedge clk);
    count_high(40, 0, ht, hc);
    check("R3", "ch0 true high clocks in 2 periods", 16'(ht), 16'd14);
    check("R4", "ch0 comp high clocks in 2 periods", 16'(hc), 16'd26);
    count_high(40, 2, ht, hc);
    check("R2", "ch2 high whole period", 16'(ht), 16'd40);
    count_high(20, 3, ht, hc);
    check("R3", "ch3 empty window", 16'(ht), 16'd0);

    // R5: gap of 3 clocks
    cur_req = "R5";
    wr(5'd1, 8'h03);
    repeat (10) @(negedge clk);
    count_high(40, 0, ht, hc);
    check("R5", "ch0 true high with gap", 16'(ht), 16'd8);
    check("R5", "ch0 comp high with gap", 16'(hc), 16'd20);
    wr(5'd1, 8'h0F);
    repeat (40) @(negedge clk);

    // R6: enables and multi mode
    cur_req = "R6";
    wr(5'd1, 8'h00);
    wr(5'd0, 8'h59);          // gens 0 and 2
    repeat (30) @(negedge clk);
    check("R6", "ch1 off true", {15'd0, pwm_o[1]}, 16'd0);
    check("R6", "ch1 off comp", {15'd0, pwmn_o[1]}, 16'd0);
    wr(5'd0, 8'hF8);          // multi clear
    repeat (30) @(negedge clk);
    check("R6", "single mode ch2 comp", {15'd0, pwmn_o[2]}, 16'd0);

    // R7: master sharing
    cur_req = "R7";
    wr(5'd0, 8'hFB);
    repeat (45) @(negedge clk);

    // R8: combining modes
    cur_req = "R8";
    wr(5'd0, 8'hF9);
    for (int m = 0; m < 16; m++) begin
      wr(5'd1, 8'(m << 4) | 8'd1);
      repeat (25) @(negedge clk);
    end

    // R9: pair off
    cur_req = "R9";
    wr(5'd1, 8'h00);
    wr(5'd0, 8'hF1);
    repeat (20) @(negedge clk);
    check("R9", "pair off true", {12'd0, pwm_o}, 16'd0);

    // R10: masked input, global enable off, then real trip
    cur_req = "R10";
    wr(5'd0, 8'hF9);          // trip globally disabled
    wr(5'd2, 8'hD2);          // irq_en, tri, lvl_t=1, lvl_c=0, mask 0010
    trip_i = 4'b0010;
    repeat (5) @(negedge clk);
    rd(5'd3, 8'h00, "R10");
    wr(5'd0, 8'hFD);          // trip globally enabled
    trip_i = 4'b0001;         // masked input
    repeat (5) @(negedge clk);
    rd(5'd3, 8'h00, "R10");
    trip_i = 4'b0010;
    @(negedge clk);
    check("R10", "forced true level", {12'd0, pwm_o}, 16'h000F);
    check("R10", "forced comp level", {12'd0, pwmn_o}, 16'h0000);
    check("R11", "irq on trip", {15'd0, irq_o}, 16'd1);

    // R11: clear while still tripping is ignored
    cur_req = "R11";
    wr(5'd3, 8'h01);
    rd(5'd3, 8'h01, "R11");
    trip_i = 4'b0000;
    repeat (4) @(negedge clk);
    check("R11", "still forced after input drop", {12'd0, pwm_o}, 16'h000F);
    wr(5'd3, 8'h01);
    rd(5'd3, 8'h00, "R11");
    repeat (20) @(negedge clk);

    // R10: select clear forces all low
    cur_req = "R10";
    wr(5'd2, 8'h32);
    trip_i = 4'b0010;
    @(negedge clk);
    check("R10", "select clear true low", {12'd0, pwm_o}, 16'd0);
    check("R10", "select clear comp low", {12'd0, pwmn_o}, 16'd0);
    trip_i = 0;
    wr(5'd3, 8'h01);
    repeat (10) @(negedge clk);

    // random mix against the model
    cur_req = "R8";
    for (int k = 0; k < 600; k++) begin
      logic [31:0] r;
      logic [4:0] a;
      logic [7:0] d;
      r = $urandom;
      a = 5'($urandom % 24);
      d = 8'($urandom);
      if (a == 5 || (a >= 8 && a[0])) d = 0;
      if (a == 4) d = 8'(d % 30 + 4);
      if (a >= 8 && !a[0]) d = 8'(d % 40);
      wr_en = (r[2:0] == 3'd0);
      wr_addr = a;
      wr_data = d;
      if (r[7:4] == 4'd0) trip_i = 4'(r[11:8]);
      @(negedge clk);
      wr_en = 0;
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule